// File: doc/BRIEF.md
# Privileged Register Access Arbiter

This block rules on a single software read or write aimed at one hypervisor-level configuration register. It compares the system-register encoding of each request with the encoding of its register. On a match it takes the requester's privilege level (0 to 3), three nested-virtualization control bits, a flag saying whether privilege level 3 exists, a trap-lower control, and a secure-debug undefined condition. From these it selects exactly one outcome. The outcome is one of five: raise an undefined instruction, trap to level 2, trap to level 3, redirect the access to a fixed memory slot, or perform the register access directly.

The decision is registered. It appears one clock after the request strobe, together with the read/write direction of that request. Every trap carries an exception class in a syndrome field. A memory redirect carries the slot offset. The register contents and the exception entry itself belong to neighbouring logic, which consumes the one-hot outcome.

Top module: `sysreg_access_arbiter`

## Requirements
- R1: Only a request whose encoding is op0=2'b11, op1=3'b100, CRn=4'b1010, CRm=4'b0110, op2=3'b001 produces a response; any other encoding leaves rsp_valid at 0 and rsp_outcome at 0 on the following cycle.
- R2: A matching request strobed on one rising edge yields rsp_valid=1 after the next rising edge, with rsp_write equal to the request's req_write; rsp_valid falls when no new matching request is strobed.
- R3: rsp_outcome is one-hot whenever rsp_valid is 1, with bit 0 = undefined, bit 1 = trap to level 2, bit 2 = trap to level 3, bit 3 = memory redirect, bit 4 = direct access.
- R4: Any matching request from level 0 gives the undefined outcome.
- R5: At level 1 with nv_ctl[2] and nv_ctl[0] both set, the outcome is memory redirect and rsp_mem_offset is 12'h948.
- R6: At level 1 with nv_ctl[0] set and nv_ctl[2] clear, the access traps: to level 3 when top_level_present and trap_lower are both 1, otherwise to level 2.
- R7: At level 1 with nv_ctl[0] clear, the outcome is undefined, whatever the other controls are.
- R8: At level 2 the access traps to level 3 when top_level_present and trap_lower are both 1; otherwise it is performed directly.
- R9: Wherever a trap to level 3 would be chosen and sdd_undef is 1, the outcome is undefined instead.
- R10: At level 3 the access is always performed directly.
- R11: rsp_syndrome_ec is 6'h18 for either trap outcome and 0 otherwise; rsp_mem_offset is 0 for any outcome other than memory redirect.
- R12: While rst_n is low, and on the first cycle after it rises, rsp_valid, rsp_write, rsp_outcome, rsp_syndrome_ec and rsp_mem_offset are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| cur_level | input | 2 | Privilege level of the requester |
| nv_ctl | input | 3 | Nested-virtualization control bits |
| top_level_present | input | 1 | Level 3 is implemented |
| trap_lower | input | 1 | Level-3 trap-lower control |
| sdd_undef | input | 1 | Secure-debug undefined condition |
| rsp_valid | output | 1 | Registered decision is present |
| rsp_write | output | 1 | Direction of the decided request |
| rsp_outcome | output | 5 | One-hot outcome vector |
| rsp_syndrome_ec | output | 6 | Exception class for traps |
| rsp_mem_offset | output | 12 | Slot offset for memory redirect |

## Verification
Random requests sweep every combination of level, nested-virtualization bits, level-3 presence, trap-lower and secure-debug condition, and mix matching with non-matching encodings. A bench function predicts each outcome for comparison. The sweep separates the two level-1 patterns, 1x1 against only bit 0 set. Fixed cases follow. One flips each encoding field by one bit, which shows that the match covers every field. Others toggle trap-lower and level-3 presence on their own at levels 1 and 2, which tells trap-to-3 apart from trap-to-2 and from direct access. Setting the secure-debug condition on the paths that would trap to level 3 separates the undefined override from a plain trap. Back-to-back and gapped strobes show the one-cycle latency and the write-direction pass-through.

// File: rtl/sra_pkg.sv
// Package: shared widths, outcome bit positions and request structures for
// the privileged register access arbiter.
// Assumes: outcome bit positions are decoded by downstream logic as fixed.
package sra_pkg;

    localparam int OUT_W    = 5;
    localparam int EC_W     = 6;
    localparam int OFF_W    = 12;
    localparam int LVL_W    = 2;
    localparam int NV_W     = 3;

    // Fixed outcome bit positions (a neighbour decodes these).
    localparam int IDX_UNDEF  = 0;
    localparam int IDX_TRAP2  = 1;
    localparam int IDX_TRAP3  = 2;
    localparam int IDX_MEMRED = 3;
    localparam int IDX_DIRECT = 4;

    typedef logic [OUT_W-1:0] outcome_t;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysreg_enc_t;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic [NV_W-1:0]  nv;
        logic             l3_present;
        logic             trap_lower;
        logic             sdd_undef;
    } priv_ctx_t;

endpackage

// File: rtl/sra_enc_match.sv
// Module: sra_enc_match
// Compares a request encoding with the encoding of the guarded register,
// field by field, and flags a full match.
// Assumes: the target encoding is fixed at elaboration.
module sra_enc_match
    import sra_pkg::*;
#(
    parameter logic [1:0] T_OP0 = 2'b11,
    parameter logic [2:0] T_OP1 = 3'b100,
    parameter logic [3:0] T_CRN = 4'b1010,
    parameter logic [3:0] T_CRM = 4'b0110,
    parameter logic [2:0] T_OP2 = 3'b001
) (
    input  sysreg_enc_t enc,
    output logic        hit
);
    localparam int NFIELD = 5;

    logic [NFIELD-1:0] field_eq;

    // Per-field equality, one comparator per field.
    always_comb begin
        field_eq[0] = (enc.op0 == T_OP0);
        field_eq[1] = (enc.op1 == T_OP1);
        field_eq[2] = (enc.crn == T_CRN);
        field_eq[3] = (enc.crm == T_CRM);
        field_eq[4] = (enc.op2 == T_OP2);
    end

    // Full match requires every field to agree.
    assign hit = &field_eq;

endmodule

// File: rtl/sra_policy.sv
// Module: sra_policy
// Combinational decision: maps privilege context to exactly one one-hot
// outcome, and derives the syndrome class and redirect offset from it.
// Assumes: caller qualifies the result with the encoding match.
module sra_policy
    import sra_pkg::*;
#(
    parameter logic [EC_W-1:0]  TRAP_EC    = 6'h18,
    parameter logic [OFF_W-1:0] MEM_OFFSET = 12'h948
) (
    input  priv_ctx_t          ctx,
    output outcome_t           outcome,
    output logic [EC_W-1:0]    syndrome_ec,
    output logic [OFF_W-1:0]   mem_offset
);
    logic l3_claims;     // level 3 takes over lower-level handling
    logic l3_trap_kind;  // index chosen when level 3 claims the access

    // Level 3 claims the access when it exists and asks for lower traps.
    assign l3_claims = ctx.l3_present & ctx.trap_lower;

    // A level-3 trap turns into undefined under the secure-debug condition.
    assign l3_trap_kind = ctx.sdd_undef;

    // Select one outcome from level and controls.
    always_comb begin
        outcome = '0;
        unique case (ctx.level)
            2'd0: outcome[IDX_UNDEF] = 1'b1;
            2'd1: begin
                if (ctx.nv[2] && ctx.nv[0]) begin
                    outcome[IDX_MEMRED] = 1'b1;
                end else if (ctx.nv[0]) begin
                    if (l3_claims) begin
                        if (l3_trap_kind) outcome[IDX_UNDEF] = 1'b1;
                        else              outcome[IDX_TRAP3] = 1'b1;
                    end else begin
                        outcome[IDX_TRAP2] = 1'b1;
                    end
                end else begin
                    outcome[IDX_UNDEF] = 1'b1;
                end
            end
            2'd2: begin
                if (l3_claims) begin
                    if (l3_trap_kind) outcome[IDX_UNDEF] = 1'b1;
                    else              outcome[IDX_TRAP3] = 1'b1;
                end else begin
                    outcome[IDX_DIRECT] = 1'b1;
                end
            end
            default: outcome[IDX_DIRECT] = 1'b1;
        endcase
    end

    // Syndrome class accompanies either trap kind.
    assign syndrome_ec = (outcome[IDX_TRAP2] | outcome[IDX_TRAP3]) ? TRAP_EC : '0;

    // Redirect offset accompanies only the memory redirect.
    assign mem_offset = outcome[IDX_MEMRED] ? MEM_OFFSET : '0;

endmodule

// File: rtl/sysreg_access_arbiter.sv
// Module: sysreg_access_arbiter (top)
// Decides the fate of a read or write to one hypervisor-level register and
// presents a registered one-hot outcome one cycle after the request strobe.
// Assumes: request inputs are stable around the sampling edge; synchronous
// active-low reset.
module sysreg_access_arbiter
    import sra_pkg::*;
#(
    parameter logic [EC_W-1:0]  TRAP_EC    = 6'h18,
    parameter logic [OFF_W-1:0] MEM_OFFSET = 12'h948
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_op0,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic [LVL_W-1:0]  cur_level,
    input  logic [NV_W-1:0]   nv_ctl,
    input  logic              top_level_present,
    input  logic              trap_lower,
    input  logic              sdd_undef,
    output logic              rsp_valid,
    output logic              rsp_write,
    output logic [OUT_W-1:0]  rsp_outcome,
    output logic [EC_W-1:0]   rsp_syndrome_ec,
    output logic [OFF_W-1:0]  rsp_mem_offset
);
    sysreg_enc_t      enc;
    priv_ctx_t        ctx;
    logic             hit;
    logic             take;
    outcome_t         dec_outcome;
    logic [EC_W-1:0]  dec_ec;
    logic [OFF_W-1:0] dec_off;

    // Gather request fields into packed structures.
    always_comb begin
        enc.op0        = req_op0;
        enc.op1        = req_op1;
        enc.crn        = req_crn;
        enc.crm        = req_crm;
        enc.op2        = req_op2;
        ctx.level      = cur_level;
        ctx.nv         = nv_ctl;
        ctx.l3_present = top_level_present;
        ctx.trap_lower = trap_lower;
        ctx.sdd_undef  = sdd_undef;
    end

    sra_enc_match u_match (
        .enc (enc),
        .hit (hit)
    );

    sra_policy #(
        .TRAP_EC    (TRAP_EC),
        .MEM_OFFSET (MEM_OFFSET)
    ) u_policy (
        .ctx         (ctx),
        .outcome     (dec_outcome),
        .syndrome_ec (dec_ec),
        .mem_offset  (dec_off)
    );

    // A decision is taken only for a strobed, matching request.
    assign take = req_valid & hit;

    // Register the qualified decision; clear it when nothing is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid       <= 1'b0;
            rsp_write       <= 1'b0;
            rsp_outcome     <= '0;
            rsp_syndrome_ec <= '0;
            rsp_mem_offset  <= '0;
        end else if (take) begin
            rsp_valid       <= 1'b1;
            rsp_write       <= req_write;
            rsp_outcome     <= dec_outcome;
            rsp_syndrome_ec <= dec_ec;
            rsp_mem_offset  <= dec_off;
        end else begin
            rsp_valid       <= 1'b0;
            rsp_write       <= 1'b0;
            rsp_outcome     <= '0;
            rsp_syndrome_ec <= '0;
            rsp_mem_offset  <= '0;
        end
    end

endmodule

// File: rtl/sysreg_access_arbiter_chk.sv
// Module: sysreg_access_arbiter_chk
// Property checker for the arbiter, attached by bind below.
// Assumes: the same synchronous active-low reset as the design.
module sysreg_access_arbiter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  cur_level,
    input logic        rsp_valid,
    input logic        rsp_write,
    input logic [4:0]  rsp_outcome,
    input logic [5:0]  rsp_syndrome_ec,
    input logic [11:0] rsp_mem_offset
);
    AST_ONEHOT_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot(rsp_outcome)); // R3
    AST_IDLE_NO_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_outcome == 5'd0)); // R1
    AST_WRITE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_write == $past(req_write))); // R2
    AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid)); // R2
    AST_LEVEL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(cur_level) == 2'd0) |-> rsp_outcome[0]); // R4
    AST_LEVEL3_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(cur_level) == 2'd3) |-> rsp_outcome[4]); // R10
    AST_TRAP_SYNDROME: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_outcome[1] || rsp_outcome[2]) |-> (rsp_syndrome_ec == 6'h18)); // R11
    AST_NOTRAP_NO_SYNDROME: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_outcome[1] || rsp_outcome[2]) |-> (rsp_syndrome_ec == 6'h0)); // R11
    AST_REDIRECT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_outcome[3] |-> (rsp_mem_offset == 12'h948)); // R5
    AST_NO_STRAY_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_outcome[3] |-> (rsp_mem_offset == 12'h0)); // R11
endmodule

bind sysreg_access_arbiter sysreg_access_arbiter_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_write       (req_write),
    .cur_level       (cur_level),
    .rsp_valid       (rsp_valid),
    .rsp_write       (rsp_write),
    .rsp_outcome     (rsp_outcome),
    .rsp_syndrome_ec (rsp_syndrome_ec),
    .rsp_mem_offset  (rsp_mem_offset)
);

// File: tb/sysreg_access_arbiter_tb.sv
// Bench for sysreg_access_arbiter: directed corners plus seeded random
// requests, compared against a bench-side model of the requirements.
module sysreg_access_arbiter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_op0 = '0;
    logic [2:0]  req_op1 = '0;
    logic [3:0]  req_crn = '0;
    logic [3:0]  req_crm = '0;
    logic [2:0]  req_op2 = '0;
    logic [1:0]  cur_level = '0;
    logic [2:0]  nv_ctl = '0;
    logic        top_level_present = 1'b0;
    logic        trap_lower = 1'b0;
    logic        sdd_undef = 1'b0;
    logic        rsp_valid;
    logic        rsp_write;
    logic [4:0]  rsp_outcome;
    logic [5:0]  rsp_syndrome_ec;
    logic [11:0] rsp_mem_offset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sysreg_access_arbiter u_dut (.*);

    // Bench model of the decision rules.
    function automatic logic [4:0] model(input logic [1:0] lvl, input logic [2:0] nv,
                                         input logic l3, input logic tl, input logic sdd);
        logic claim;
        claim = l3 & tl;
        case (lvl)
            2'd0: return 5'b00001;
            2'd1: begin
                if (nv[2] & nv[0]) return 5'b01000;
                if (nv[0]) return claim ? (sdd ? 5'b00001 : 5'b00100) : 5'b00010;
                return 5'b00001;
            end
            2'd2: return claim ? (sdd ? 5'b00001 : 5'b00100) : 5'b10000;
            default: return 5'b10000;
        endcase
    endfunction

    function automatic bit enc_hit(input logic [1:0] o0, input logic [2:0] o1,
                                   input logic [3:0] cn, input logic [3:0] cm,
                                   input logic [2:0] o2);
        return o0 == 2'b11 && o1 == 3'b100 && cn == 4'b1010 && cm == 4'b0110 && o2 == 3'b001;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one request, then check the registered response after the edge.
    task automatic do_req(input string tag, input logic w, input logic [1:0] o0,
                          input logic [2:0] o1, input logic [3:0] cn, input logic [3:0] cm,
                          input logic [2:0] o2, input logic [1:0] lvl, input logic [2:0] nv,
                          input logic l3, input logic tl, input logic sdd);
        logic [4:0] eo;
        bit h;
        @(negedge clk);
        req_valid = 1'b1; req_write = w;
        req_op0 = o0; req_op1 = o1; req_crn = cn; req_crm = cm; req_op2 = o2;
        cur_level = lvl; nv_ctl = nv; top_level_present = l3; trap_lower = tl; sdd_undef = sdd;
        @(posedge clk); #1;
        h  = enc_hit(o0, o1, cn, cm, o2);
        eo = h ? model(lvl, nv, l3, tl, sdd) : 5'b0;
        chk({tag, " R2 valid"}, rsp_valid, h);
        chk({tag, " R2 write"}, rsp_write, h ? w : 1'b0);
        chk({tag, " R3 outcome"}, rsp_outcome, eo);
        chk({tag, " R11 ec"}, rsp_syndrome_ec, (eo[1] | eo[2]) ? 6'h18 : 6'h0);
        chk({tag, " R5 offset"}, rsp_mem_offset, eo[3] ? 12'h948 : 12'h0);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic hit_req(input string tag, input logic w, input logic [1:0] lvl,
                           input logic [2:0] nv, input logic l3, input logic tl,
                           input logic sdd);
        do_req(tag, w, 2'b11, 3'b100, 4'b1010, 4'b0110, 3'b001, lvl, nv, l3, tl, sdd);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        // R12: reset state, during reset and first cycle after.
        repeat (3) @(posedge clk);
        #1;
        chk("R12 valid in reset", rsp_valid, 0);
        chk("R12 outcome in reset", rsp_outcome, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R12 valid after reset", rsp_valid, 0);
        chk("R12 ec/offset after reset", {rsp_syndrome_ec, rsp_mem_offset}, 0);

        // Directed corners.
        hit_req("R4 lvl0", 1'b0, 2'd0, 3'b101, 1'b1, 1'b1, 1'b0);
        hit_req("R5 lvl1 nv101", 1'b1, 2'd1, 3'b101, 1'b1, 1'b1, 1'b1);
        hit_req("R5 lvl1 nv111", 1'b0, 2'd1, 3'b111, 1'b0, 1'b0, 1'b0);
        hit_req("R6 lvl1 trap2", 1'b0, 2'd1, 3'b011, 1'b1, 1'b0, 1'b0);
        hit_req("R6 lvl1 trap2 noL3", 1'b1, 2'd1, 3'b001, 1'b0, 1'b1, 1'b0);
        hit_req("R6 lvl1 trap3", 1'b1, 2'd1, 3'b001, 1'b1, 1'b1, 1'b0);
        hit_req("R9 lvl1 sdd", 1'b0, 2'd1, 3'b001, 1'b1, 1'b1, 1'b1);
        hit_req("R7 lvl1 nv110", 1'b0, 2'd1, 3'b110, 1'b1, 1'b1, 1'b0);
        hit_req("R8 lvl2 direct", 1'b1, 2'd2, 3'b000, 1'b1, 1'b0, 1'b1);
        hit_req("R8 lvl2 trap3", 1'b0, 2'd2, 3'b000, 1'b1, 1'b1, 1'b0);
        hit_req("R9 lvl2 sdd", 1'b1, 2'd2, 3'b101, 1'b1, 1'b1, 1'b1);
        hit_req("R10 lvl3", 1'b1, 2'd3, 3'b001, 1'b1, 1'b1, 1'b1);
        // R1: each field off by one bit.
        do_req("R1 op0", 1'b0, 2'b10, 3'b100, 4'b1010, 4'b0110, 3'b001, 2'd3, 3'b0, 1'b0, 1'b0, 1'b0);
        do_req("R1 op1", 1'b0, 2'b11, 3'b101, 4'b1010, 4'b0110, 3'b001, 2'd3, 3'b0, 1'b0, 1'b0, 1'b0);
        do_req("R1 crn", 1'b0, 2'b11, 3'b100, 4'b1011, 4'b0110, 3'b001, 2'd3, 3'b0, 1'b0, 1'b0, 1'b0);
        do_req("R1 crm", 1'b0, 2'b11, 3'b100, 4'b1010, 4'b0111, 3'b001, 2'd3, 3'b0, 1'b0, 1'b0, 1'b0);
        do_req("R1 op2", 1'b0, 2'b11, 3'b100, 4'b1010, 4'b0110, 3'b011, 2'd3, 3'b0, 1'b0, 1'b0, 1'b0);
        // R2: idle cycle after a response clears it.
        @(posedge clk); #1;
        chk("R2 idle clears valid", rsp_valid, 0);

        // Seeded random mix, mostly matching encodings.
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] < 4'd11)
                hit_req("RND", r[4], r[6:5], r[9:7], r[10], r[11], r[12]);
            else
                do_req("RND R1", r[4], r[14:13], r[17:15], r[21:18], r[25:22], r[28:26],
                       r[6:5], r[9:7], r[10], r[11], r[12]);
        end
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule